// File: doc/BRIEF.md
# CAN Interrupt Source Aggregator

This block merges every interrupt source of a CAN controller into one request line for the processor. Fifteen message centers each keep a pending flag. A flag sets when the center completes a reception or a transmission and the matching per-center enable is on. It stays set until software clears it. A small encoder tells software which center to service: it reports the lowest-numbered center that is pending.

The block also holds the controller's readable status register. Status activity is sorted into two groups, and each group has its own enable. The first group covers the success bits, the wake bit and the error code. The second covers the bus-off and error-count-threshold bits. Each group keeps one pending flag. A read of the status register clears both group flags, so a burst of changes before that read gives only one interrupt. The final request is gated by a module enable and a global enable.

Top module: `can_irq_aggregator`

## Requirements
- R1: After reset, `irq` is 0, `pend_id` is 0 and `status` is 0x00.
- R2: Bit i of `rx_done`, `tx_done`, `rx_ie`, `tx_ie` and `ctr_clr` belongs to center i+1. A center's pending flag sets on the clock edge where `rx_done` and `rx_ie`, or `tx_done` and `tx_ie`, are both high for it. A completion whose enable is low does not set the flag.
- R3: A center's pending flag stays set until its `ctr_clr` bit is pulsed. When a set and a clear arrive in the same cycle, the set wins.
- R4: `pend_id` gives the number (1 to 15) of the lowest-numbered pending center, or 0 when no center is pending. It reflects a flag change right after the edge that changes the flag.
- R5: The status bit layout is: bit0 receive success, bit1 transmit success, bit2 wake, bits 5:3 error code, bit6 bus-off, bit7 error-count threshold.
  - `set_rxs`, `set_txs` and `set_wake` set bits 0 to 2.
  - The bits of `clr_succ` clear bits 0 to 2 in the same order, and a set beats a clear.
  - `err_we` loads `err_in` into bits 5:3.
  - Bits 6 and 7 follow `busoff_in` and `ecthr_in` one edge later.
- R6: These are group A events: a pulse on `set_rxs`, `set_txs` or `set_wake`, or an `err_we` whose `err_in` differs from the stored code. A group A event latches the group A pending flag when `grp_a_ie` is high. An `err_we` with an unchanged code is not an event.
- R7: A change of `busoff_in` or `ecthr_in` from the stored bit is a group B event. It latches the group B pending flag when `grp_b_ie` is high.
- R8: A pulse on `stat_rd` clears both group pending flags. An event of an enabled group in the same cycle keeps that group's flag set.
- R9: Several group events before a status read leave one pending flag, and a single read removes the request.
- R10: A success event that arrives after a status read raises a new request, even if the success bit is still set from before.
- R11: `irq` is high when both `mod_ie` and `glb_ie` are high and at least one of these holds: some center is pending, group A is pending with `grp_a_ie` high, or group B is pending with `grp_b_ie` high. The gating is combinational.
- R12: A group event that arrives while its group enable is low is not remembered. Raising the enable later produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 15 | Per-center reception success pulses |
| tx_done | input | 15 | Per-center transmission success pulses |
| rx_ie | input | 15 | Per-center receive interrupt enables |
| tx_ie | input | 15 | Per-center transmit interrupt enables |
| ctr_clr | input | 15 | Per-center software clear pulses |
| set_rxs | input | 1 | Receive success status event |
| set_txs | input | 1 | Transmit success status event |
| set_wake | input | 1 | Wake status event |
| err_we | input | 1 | Error code update strobe |
| err_in | input | 3 | New error code |
| busoff_in | input | 1 | Bus-off level from the protocol engine |
| ecthr_in | input | 1 | Error-count-threshold level |
| clr_succ | input | 3 | Software clear of receive, transmit and wake bits |
| stat_rd | input | 1 | Host read of the status register |
| grp_a_ie | input | 1 | Group A interrupt enable |
| grp_b_ie | input | 1 | Group B interrupt enable |
| mod_ie | input | 1 | Module interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |
| pend_id | output | 4 | Lowest pending center number, 0 if none |
| status | output | 8 | Readable status register |

## Verification
Every flag is one register stage away from its inputs. A completion, status event, clear or read applied in one cycle therefore shows on `pend_id`, `status` and `irq` just after the next rising edge. The bench changes its inputs two time units after an edge, calls one edge, removes the pulses and samples at once. Each sample therefore falls inside the cycle in which the result is due. The enable gating of `irq` has no register in its path, so those checks change an enable and sample after a short delay without any clock.

// File: rtl/can_irq_pkg.sv
// Package: shared constants for the CAN interrupt aggregator.
// Assumes an 8-bit status register with the layout fixed below.
package can_irq_pkg;
    localparam int STAT_W   = 8;
    localparam int ERR_W    = 3;
    localparam int B_RXS    = 0;
    localparam int B_TXS    = 1;
    localparam int B_WKS    = 2;
    localparam int B_ERR_LO = 3;
    localparam int B_BOFF   = 6;
    localparam int B_ECTH   = 7;

    typedef struct packed {
        logic             ecth;
        logic             boff;
        logic [ERR_W-1:0] err;
        logic             wks;
        logic             txs;
        logic             rxs;
    } status_t;
endpackage

// File: rtl/can_irq_center_bank.sv
// Module: per-center pending flags.
// Each flag sets on an enabled completion and clears on a software pulse.
// Set has priority over clear. Assumes pulses last one cycle.
module can_irq_center_bank #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rx_done,
    input  logic [N-1:0] tx_done,
    input  logic [N-1:0] rx_ie,
    input  logic [N-1:0] tx_ie,
    input  logic [N-1:0] ctr_clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic hit;
        logic flag_q;
        // qualify the completion pulses with their enables
        assign hit = (rx_done[i] & rx_ie[i]) | (tx_done[i] & tx_ie[i]);
        // hold the sticky pending flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (hit)        flag_q <= 1'b1;
            else if (ctr_clr[i]) flag_q <= 1'b0;
        end
        assign pend[i] = flag_q;
    end
endmodule

// File: rtl/can_irq_prio_enc.sv
// Module: lowest-index priority encoder.
// Output is the 1-based number of the lowest set bit, 0 when none.
// Assumes ID_W can hold the value N.
module can_irq_prio_enc #(
    parameter int N    = 15,
    parameter int ID_W = 4
) (
    input  logic [N-1:0]    req,
    output logic [ID_W-1:0] id
);
    // scan from the top so the lowest index is written last
    always_comb begin
        id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) id = ID_W'(i + 1);
        end
    end
endmodule

// File: rtl/can_irq_status_unit.sv
// Module: status register and the two group interrupt flags.
// Group A covers the success, wake and error-code bits.
// Group B covers the bus-off and threshold bits.
// A status read clears both flags, and an enabled event in the same cycle wins.
module can_irq_status_unit
    import can_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rxs,
    input  logic             set_txs,
    input  logic             set_wake,
    input  logic             err_we,
    input  logic [ERR_W-1:0] err_in,
    input  logic             busoff_in,
    input  logic             ecthr_in,
    input  logic [2:0]       clr_succ,
    input  logic             stat_rd,
    input  logic             grp_a_ie,
    input  logic             grp_b_ie,
    output status_t          stat,
    output logic             ga_set,
    output logic             ga_pend,
    output logic             gb_pend,
    output logic             ga_req,
    output logic             gb_req
);
    status_t st_q;
    logic    ga_q, gb_q;
    logic    ga_evt, gb_evt, gb_set;

    // detect activity in each group
    always_comb begin
        ga_evt = set_rxs | set_txs | set_wake | (err_we && (err_in != st_q.err));
        gb_evt = (busoff_in != st_q.boff) | (ecthr_in != st_q.ecth);
        ga_set = ga_evt & grp_a_ie;
        gb_set = gb_evt & grp_b_ie;
    end

    // update the status register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (set_rxs)          st_q.rxs <= 1'b1;
            else if (clr_succ[0]) st_q.rxs <= 1'b0;
            if (set_txs)          st_q.txs <= 1'b1;
            else if (clr_succ[1]) st_q.txs <= 1'b0;
            if (set_wake)         st_q.wks <= 1'b1;
            else if (clr_succ[2]) st_q.wks <= 1'b0;
            if (err_we)           st_q.err <= err_in;
            st_q.boff <= busoff_in;
            st_q.ecth <= ecthr_in;
        end
    end

    // latch the coalesced group flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ga_q <= 1'b0;
            gb_q <= 1'b0;
        end else begin
            if (ga_set)       ga_q <= 1'b1;
            else if (stat_rd) ga_q <= 1'b0;
            if (gb_set)       gb_q <= 1'b1;
            else if (stat_rd) gb_q <= 1'b0;
        end
    end

    assign stat    = st_q;
    assign ga_pend = ga_q;
    assign gb_pend = gb_q;
    assign ga_req  = ga_q & grp_a_ie;
    assign gb_req  = gb_q & grp_b_ie;
endmodule

// File: rtl/can_irq_aggregator.sv
// Module: top of the CAN interrupt aggregator.
// Merges the per-center flags and the two status groups into one request.
// The request is gated by the module and global enables.
// Assumes all event inputs are synchronous one-cycle pulses.
module can_irq_aggregator
    import can_irq_pkg::*;
#(
    parameter int N_CTR = 15,
    parameter int ID_W  = $clog2(N_CTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CTR-1:0]  rx_done,
    input  logic [N_CTR-1:0]  tx_done,
    input  logic [N_CTR-1:0]  rx_ie,
    input  logic [N_CTR-1:0]  tx_ie,
    input  logic [N_CTR-1:0]  ctr_clr,
    input  logic              set_rxs,
    input  logic              set_txs,
    input  logic              set_wake,
    input  logic              err_we,
    input  logic [2:0]        err_in,
    input  logic              busoff_in,
    input  logic              ecthr_in,
    input  logic [2:0]        clr_succ,
    input  logic              stat_rd,
    input  logic              grp_a_ie,
    input  logic              grp_b_ie,
    input  logic              mod_ie,
    input  logic              glb_ie,
    output logic              irq,
    output logic [ID_W-1:0]   pend_id,
    output logic [STAT_W-1:0] status
);
    logic [N_CTR-1:0] ctr_pend;
    status_t          stat_s;
    logic             ga_set, ga_pend, gb_pend, ga_req, gb_req;

    can_irq_center_bank #(.N(N_CTR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_done (rx_done),
        .tx_done (tx_done),
        .rx_ie   (rx_ie),
        .tx_ie   (tx_ie),
        .ctr_clr (ctr_clr),
        .pend    (ctr_pend)
    );

    can_irq_prio_enc #(.N(N_CTR), .ID_W(ID_W)) u_enc (
        .req (ctr_pend),
        .id  (pend_id)
    );

    can_irq_status_unit u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rxs   (set_rxs),
        .set_txs   (set_txs),
        .set_wake  (set_wake),
        .err_we    (err_we),
        .err_in    (err_in),
        .busoff_in (busoff_in),
        .ecthr_in  (ecthr_in),
        .clr_succ  (clr_succ),
        .stat_rd   (stat_rd),
        .grp_a_ie  (grp_a_ie),
        .grp_b_ie  (grp_b_ie),
        .stat      (stat_s),
        .ga_set    (ga_set),
        .ga_pend   (ga_pend),
        .gb_pend   (gb_pend),
        .ga_req    (ga_req),
        .gb_req    (gb_req)
    );

    // combine the sources and apply the two gating enables
    always_comb begin
        irq = mod_ie & glb_ie & ((|ctr_pend) | ga_req | gb_req);
    end

    assign status = stat_s;
endmodule

// File: rtl/can_irq_checker.sv
// Module: assertion checker for can_irq_aggregator, attached by bind.
// It only observes and drives nothing.
module can_irq_checker #(
    parameter int N    = 15,
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            mod_ie,
    input logic            glb_ie,
    input logic [N-1:0]    rx_done,
    input logic [N-1:0]    tx_done,
    input logic [N-1:0]    rx_ie,
    input logic [N-1:0]    tx_ie,
    input logic [N-1:0]    ctr_clr,
    input logic [N-1:0]    ctr_pend,
    input logic [ID_W-1:0] pend_id,
    input logic            stat_rd,
    input logic            ga_set,
    input logic            ga_pend,
    input logic            busoff_in,
    input logic [7:0]      status
);
    logic [N-1:0] below;
    // mask of the centers numbered below the reported one
    always_comb begin
        below = (pend_id == '0) ? '0 : ((N'(1) << (pend_id - 1'b1)) - N'(1));
    end

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_ie && glb_ie) |-> !irq); // R11
    AST_CTR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|((rx_done & rx_ie) | (tx_done & tx_ie))) |=> (pend_id != '0)); // R2
    AST_CTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ctr_pend & ~ctr_clr) & ~ctr_pend) == '0)); // R3
    AST_ID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_pend != '0) |-> (pend_id != '0) && ((ctr_pend & below) == '0)); // R4
    AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_pend == '0) |-> (pend_id == '0)); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ga_set) |=> !ga_pend); // R8
    AST_BUSOFF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[6] == $past(busoff_in))); // R5
endmodule

bind can_irq_aggregator can_irq_checker #(.N(N_CTR), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mod_ie    (mod_ie),
    .glb_ie    (glb_ie),
    .rx_done   (rx_done),
    .tx_done   (tx_done),
    .rx_ie     (rx_ie),
    .tx_ie     (tx_ie),
    .ctr_clr   (ctr_clr),
    .ctr_pend  (ctr_pend),
    .pend_id   (pend_id),
    .stat_rd   (stat_rd),
    .ga_set    (ga_set),
    .ga_pend   (ga_pend),
    .busoff_in (busoff_in),
    .status    (status)
);

// File: tb/tb_can_irq_aggregator.sv
// Bench: a table of center vectors first, then directed status, gating and reset tests.
module tb_can_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int N = 15;

    typedef struct packed {
        logic [N-1:0] rxd;
        logic [N-1:0] txd;
        logic [N-1:0] rxe;
        logic [N-1:0] txe;
        logic [N-1:0] clr;
        logic [3:0]   id;
        logic         rq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{15'h0010, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h0000, 4'd5,  1'b1},
        '{15'h0000, 15'h0002, 15'h7FFF, 15'h0000, 15'h0000, 4'd5,  1'b1},
        '{15'h0000, 15'h0002, 15'h7FFF, 15'h0002, 15'h0000, 4'd2,  1'b1},
        '{15'h0000, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h0002, 4'd5,  1'b1},
        '{15'h4000, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h0010, 4'd15, 1'b1},
        '{15'h0001, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h0001, 4'd1,  1'b1},
        '{15'h0000, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h4001, 4'd0,  1'b0},
        '{15'h0080, 15'h0000, 15'h7F7F, 15'h7FFF, 15'h0000, 4'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] rx_done, tx_done, rx_ie, tx_ie, ctr_clr;
    logic set_rxs, set_txs, set_wake, err_we, busoff_in, ecthr_in, stat_rd;
    logic [2:0] err_in, clr_succ;
    logic grp_a_ie, grp_b_ie, mod_ie, glb_ie;
    logic irq;
    logic [3:0] pend_id;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .ctr_clr(ctr_clr), .set_rxs(set_rxs),
        .set_txs(set_txs), .set_wake(set_wake), .err_we(err_we), .err_in(err_in),
        .busoff_in(busoff_in), .ecthr_in(ecthr_in), .clr_succ(clr_succ),
        .stat_rd(stat_rd), .grp_a_ie(grp_a_ie), .grp_b_ie(grp_b_ie),
        .mod_ie(mod_ie), .glb_ie(glb_ie), .irq(irq), .pend_id(pend_id),
        .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_pulses();
        rx_done = '0; tx_done = '0; ctr_clr = '0;
        set_rxs = 0; set_txs = 0; set_wake = 0; err_we = 0;
        clr_succ = '0; stat_rd = 0;
    endtask

    // one edge, then drop the pulses; sampling follows in the same cycle
    task automatic tick();
        @(posedge clk);
        #2;
        clear_pulses();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        clear_pulses();
        rx_ie = '0; tx_ie = '0; err_in = '0; busoff_in = 0; ecthr_in = 0;
        grp_a_ie = 0; grp_b_ie = 0; mod_ie = 1; glb_ie = 1;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 pend_id", pend_id, 0);
        chk("R1 status", status, 8'h00);

        // center vectors (R2 R3 R4)
        foreach (VECS[k]) begin
            rx_done = VECS[k].rxd; tx_done = VECS[k].txd;
            rx_ie = VECS[k].rxe;   tx_ie = VECS[k].txe;
            ctr_clr = VECS[k].clr;
            tick();
            chk($sformatf("R2 R3 R4 vec%0d id", k), pend_id, VECS[k].id);
            chk($sformatf("R11 vec%0d irq", k), irq, VECS[k].rq);
        end
        rx_ie = '1; tx_ie = '1;

        // group A events: R5 R6
        grp_a_ie = 1; set_rxs = 1; tick();
        chk("R5 status rxs", status, 8'h01);
        chk("R6 irq", irq, 1);
        set_txs = 1; tick();
        err_we = 1; err_in = 3'd3; tick();
        chk("R5 status err", status, 8'h1B);
        stat_rd = 1; tick();
        chk("R9 irq after read", irq, 0);
        chk("R9 status kept", status, 8'h1B);
        set_rxs = 1; tick();
        chk("R10 second success", irq, 1);
        stat_rd = 1; set_wake = 1; tick();
        chk("R8 event beats read", irq, 1);
        chk("R5 status wake", status, 8'h1F);
        stat_rd = 1; tick();
        chk("R8 read clears", irq, 0);
        err_we = 1; err_in = 3'd3; tick();
        chk("R6 same code no event", irq, 0);

        // R12 disabled event forgotten
        grp_a_ie = 0; set_txs = 1; tick();
        chk("R12 disabled irq", irq, 0);
        grp_a_ie = 1; tick();
        chk("R12 late enable", irq, 0);

        clr_succ = 3'b011; tick();
        chk("R5 clear success", status, 8'h1C);

        // group B: R7
        grp_b_ie = 1; busoff_in = 1; tick();
        chk("R7 busoff status", status, 8'h5C);
        chk("R7 busoff irq", irq, 1);
        stat_rd = 1; tick();
        chk("R8 group B read", irq, 0);
        grp_b_ie = 0; ecthr_in = 1; tick();
        chk("R5 threshold bit", status, 8'hDC);
        chk("R12 group B disabled", irq, 0);
        grp_b_ie = 1; tick();
        chk("R12 group B late enable", irq, 0);

        // R11 gating
        rx_done = 15'h0004; tick();
        chk("R4 id center3", pend_id, 3);
        chk("R11 irq on", irq, 1);
        mod_ie = 0; #1;
        chk("R11 module gate", irq, 0);
        mod_ie = 1; glb_ie = 0; #1;
        chk("R11 global gate", irq, 0);
        glb_ie = 1; #1;
        chk("R11 regated on", irq, 1);
        ctr_clr = 15'h0004; tick();
        chk("R3 cleared id", pend_id, 0);
        chk("R3 cleared irq", irq, 0);

        // R1 reset mid-run
        rx_done = 15'h0100; set_rxs = 1; tick();
        rst_n = 0; busoff_in = 0; ecthr_in = 0; tick();
        rst_n = 1; #1;
        chk("R1 reset id", pend_id, 0);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset irq", irq, 0);
        finish_run();
    end
endmodule